// File: doc/BRIEF.md
# Serial Control Register Loader

This block is a write-only two-wire serial slave that fills a bank of ten 8-bit control registers steering an audio signal path. It runs on a fast system clock. The serial clock and data lines pass through synchronizers and are oversampled by that clock. The block detects start and stop conditions on the bus and compares the first byte with a device address chosen by a strap pin. It acknowledges each accepted byte by enabling an open-drain pull-down. Every register is exposed as a parallel output for the analog control logic.

After the device address, the master sends a subaddress byte. Its low nibble selects a register and its top bit selects the write pattern. With that bit clear, every following data byte lands in the same register. With it set, the index steps up by one per data byte and wraps from 15 to 0. Indices 10 to 15 have no storage. Bytes aimed at them are acknowledged and discarded.

Top module: `ctl_i2c_regfile`

## Requirements
- R1: Bytes are taken only after a START (SDA falling while SCL is high). A STOP (SDA rising while SCL is high) ends the transfer, and bytes clocked in outside a transfer are neither acknowledged nor written.
- R2: The device address is 0x80 when `addr_sel_i` is 0 and 0x82 when it is 1. A matching address byte, the subaddress byte and every data byte get an acknowledge: `sda_pd_o` is high during the ninth SCL clock. It changes only while SCL is low.
- R3: After an address byte that does not match, `sda_pd_o` stays low and no register changes until the next START.
- R4: Subaddress bits [3:0] are the register index and bit 7 is the increment flag. Bits [6:4] have no effect.
- R5: With the flag at 0, every data byte up to STOP is written to the selected register. The last byte remains.
- R6: With the flag at 1, data byte k (counting from 0) goes to index (selected index + k) mod 16.
- R7: Data for indices 10 to 15 changes no register and is still acknowledged.
- R8: After reset, the registers hold these values: index 0 = 0x3F (input attenuation at maximum, rear path enabled); 1 = 0x3F; 2 = 0x00; 3 = 0x07 (bass flat, natural bass off); 4 = 0x77 (middle and treble at the 0 dB code 0111); 5 to 8 = 0x78 (mute code); 9 = 0x03 (voice canceller off in bit 7, input mux bits [1:0] = 11 selecting input 1). `sda_pd_o` is 0 after reset.
- R9: A STOP inside a byte discards the partial byte. A repeated START at any point restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line (asynchronous) |
| sda_i | input | 1 | Serial data line as seen on the bus (asynchronous) |
| addr_sel_i | input | 1 | Address strap: 0 selects 0x80, 1 selects 0x82 |
| sda_pd_o | output | 1 | Active-high enable of the SDA pull-down |
| regs_o | output | 80 | Register contents, index i at bits [8i+7:8i] |

## Verification
A wrong state in the receive controller shows up at the ports quickly. If the address check is wrong, the pull-down is missing or spurious in the very next ninth clock. If the index or the increment flag is wrong, the wrong output byte changes about one system cycle after the eighth data bit is sampled. If the bit counter drifts, the acknowledge is misplaced within one byte, and a master that checks acknowledges sees this at once. If the ignored-index filter fails, the fault stays hidden until a write aims past index 9, or until a wrapping burst rewrites register 0 instead of skipping indices 10 to 15. Both cases are therefore driven deliberately alongside random transfers.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_DATA,
    ST_SKIP
  } rx_state_e;

  function automatic logic [BYTE_W-1:0] reg_default(int unsigned idx);
    case (idx)
      0, 1:          return 8'h3F;
      2:             return 8'h00;
      3:             return 8'h07;
      4:             return 8'h77;
      5, 6, 7, 8:    return 8'h78;
      9:             return 8'h03;
      default:       return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned MSB = STAGES - 1;

  logic [MSB:0] scl_sr, sda_sr;
  logic         scl_q, sda_q;
  logic         scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[MSB-1:0], scl_i};
      sda_sr <= {sda_sr[MSB-1:0], sda_i};
      scl_q  <= scl_sr[MSB];
      sda_q  <= sda_sr[MSB];
    end
  end

  assign scl_s      = scl_sr[MSB];
  assign sda_o      = sda_sr[MSB];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx
  import ctl_i2c_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              ack_req_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              sda_pd_o
);
  localparam logic [3:0] CNT_LAST = 4'(BYTE_W - 1);
  localparam logic [3:0] CNT_ACK  = 4'(BYTE_W);
  localparam logic [3:0] CNT_HOLD = 4'(BYTE_W + 1);

  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      sh_q       <= '0;
      ack_q      <= 1'b0;
      byte_vld_o <= 1'b0;
      sda_pd_o   <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (byte_vld_o) ack_q <= ack_req_i;
      if (start_i || stop_i) begin
        cnt_q    <= '0;
        sda_pd_o <= 1'b0;
      end else if (scl_rise_i && cnt_q < CNT_ACK) begin
        sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
        cnt_q <= cnt_q + 4'd1;
        if (cnt_q == CNT_LAST) byte_vld_o <= 1'b1;
      end else if (scl_fall_i && cnt_q == CNT_ACK) begin
        sda_pd_o <= ack_q;
        cnt_q    <= CNT_HOLD;
      end else if (scl_fall_i && cnt_q == CNT_HOLD) begin
        sda_pd_o <= 1'b0;
        cnt_q    <= '0;
      end
    end
  end

  assign byte_o = sh_q;
endmodule

// File: rtl/i2c_wr_ctrl.sv
module i2c_wr_ctrl
  import ctl_i2c_pkg::*;
#(
  parameter int unsigned     NREG      = 10,
  parameter logic [7:0]      ADDR_BASE = 8'h80,
  parameter logic [7:0]      ADDR_ALT  = 8'h82
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              addr_sel_i,
  output logic              ack_req_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(NREG - 1);

  rx_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic             inc_q;
  logic [7:0]       dev_addr;

  assign dev_addr = addr_sel_i ? ADDR_ALT : ADDR_BASE;

  always_comb begin
    case (state_q)
      ST_ADDR:        ack_req_o = (byte_i == dev_addr);
      ST_SUB, ST_DATA: ack_req_o = 1'b1;
      default:        ack_req_o = 1'b0;
    endcase
  end

  assign wr_en_o   = byte_vld_i && (state_q == ST_DATA) && (idx_q <= IDX_TOP);
  assign wr_idx_o  = idx_q;
  assign wr_data_o = byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      inc_q   <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
    end else if (byte_vld_i) begin
      case (state_q)
        ST_ADDR: state_q <= (byte_i == dev_addr) ? ST_SUB : ST_SKIP;
        ST_SUB: begin
          idx_q   <= byte_i[IDX_W-1:0];
          inc_q   <= byte_i[BYTE_W-1];
          state_q <= ST_DATA;
        end
        ST_DATA: if (inc_q) idx_q <= idx_q + 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import ctl_i2c_pkg::*;
#(
  parameter int unsigned NREG = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic [BYTE_W-1:0]      wr_data_i,
  output logic [NREG*BYTE_W-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [BYTE_W-1:0] RST_VAL = reg_default(g);
    localparam logic [IDX_W-1:0]  MY_IDX  = IDX_W'(g);
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            q <= RST_VAL;
      else if (wr_en_i && wr_idx_i == MY_IDX) q <= wr_data_i;
    end
    assign regs_o[g*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/ctl_i2c_regfile.sv
module ctl_i2c_regfile
  import ctl_i2c_pkg::*;
#(
  parameter int unsigned NREG      = 10,
  parameter int unsigned SYNC      = 2,
  parameter logic [7:0]  ADDR_BASE = 8'h80,
  parameter logic [7:0]  ADDR_ALT  = 8'h82
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  input  logic                   addr_sel_i,
  output logic                   sda_pd_o,
  output logic [NREG*BYTE_W-1:0] regs_o
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              ack_req, byte_vld, wr_en;
  logic [BYTE_W-1:0] rx_byte, wr_data;
  logic [IDX_W-1:0]  wr_idx;

  i2c_line_sync #(.STAGES(SYNC)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_byte_rx u_rx (
    .clk_i, .rst_ni, .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .ack_req_i(ack_req),
    .byte_o(rx_byte), .byte_vld_o(byte_vld), .sda_pd_o(sda_pd_o)
  );

  i2c_wr_ctrl #(.NREG(NREG), .ADDR_BASE(ADDR_BASE), .ADDR_ALT(ADDR_ALT)) u_ctrl (
    .clk_i, .rst_ni, .start_i(start_det), .stop_i(stop_det),
    .byte_vld_i(byte_vld), .byte_i(rx_byte), .addr_sel_i,
    .ack_req_o(ack_req), .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  cfg_regbank #(.NREG(NREG)) u_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .regs_o
  );
endmodule

// File: rtl/ctl_i2c_regfile_chk.sv
module ctl_i2c_regfile_chk #(
  parameter int unsigned NREG = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_pd_o,
  input logic              stop_i,
  input logic              wr_en_i,
  input logic [3:0]        wr_idx_i,
  input logic [NREG*8-1:0] regs_i
);
  logic [NREG*8-1:0] regs_q;
  logic              wr_q, vld_q;
  logic [NREG-1:0]   chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
      wr_q   <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      regs_q <= regs_i;
      wr_q   <= wr_en_i;
      vld_q  <= 1'b1;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_chg
    assign chg[g] = regs_i[g*8 +: 8] != regs_q[g*8 +: 8];
  end

  a_r2_pd_rises_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pd_o) |-> !scl_i);
  a_r9_stop_releases_sda: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_pd_o);
  a_r7_write_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (int'(wr_idx_i) < NREG));
  a_r5_one_reg_per_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> $onehot0(chg));
  a_r3_regs_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !wr_q) |-> (chg == '0));
endmodule

bind ctl_i2c_regfile ctl_i2c_regfile_chk #(.NREG(NREG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_pd_o(sda_pd_o),
  .stop_i(stop_det), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .regs_i(regs_o)
);

// File: tb/tb_ctl_i2c_regfile.sv
module tb_ctl_i2c_regfile;
  localparam int CLK_P = 10;
  localparam int NREG  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_bus, sda_pd;
  logic [NREG*8-1:0] regs;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q [16];
  logic [7:0] dbuf [16];

  always #(CLK_P/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_pd;

  ctl_i2c_regfile dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel_i(strap), .sda_pd_o(sda_pd), .regs_o(regs)
  );

  function automatic logic [7:0] def_val(int i);
    if (i <= 1) return 8'h3F;
    if (i == 2) return 8'h00;
    if (i == 3) return 8'h07;
    if (i == 4) return 8'h77;
    if (i <= 8) return 8'h78;
    return 8'h03;
  endfunction

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(string tag);
    for (int i = 0; i < NREG; i++)
      check(regs[i*8 +: 8] == exp_q[i], tag, regs[i*8 +: 8], exp_q[i]);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(4); scl_m = 1'b1; wt(4); sda_m = 1'b0; wt(4); scl_m = 1'b0; wt(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(4); scl_m = 1'b1; wt(4); sda_m = 1'b1; wt(8);
  endtask

  task automatic put_bit(logic b);
    sda_m = b; wt(4); scl_m = 1'b1; wt(8); scl_m = 1'b0; wt(4);
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; wt(4); scl_m = 1'b1; wt(4);
    ack = sda_pd;
    wt(4); scl_m = 1'b0; wt(4);
  endtask

  // full write transfer with model update; data in dbuf[0..n-1]
  task automatic xfer(logic [7:0] addr, logic [7:0] sub, int n, string tag);
    logic ack;
    logic match;
    logic [3:0] idx;
    match = (addr == (strap ? 8'h82 : 8'h80));
    bus_start();
    send_byte(addr, ack);
    check(ack == match, {tag, " R2 addr ack"}, {7'd0, ack}, {7'd0, match});
    send_byte(sub, ack);
    check(ack == match, {tag, " R4 sub ack"}, {7'd0, ack}, {7'd0, match});
    idx = sub[3:0];
    for (int k = 0; k < n; k++) begin
      send_byte(dbuf[k], ack);
      check(ack == match, {tag, " R7 data ack"}, {7'd0, ack}, {7'd0, match});
      if (match) begin
        if (idx < 4'd10) exp_q[idx] = dbuf[k];
        if (sub[7]) idx = idx + 4'd1;
      end
    end
    bus_stop();
    chk_regs(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack;
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) exp_q[i] = def_val(i);
    wt(5); rst_n = 1'b1; wt(5);

    // R8 reset values
    chk_regs("R8 reset");
    check(sda_pd == 1'b0, "R8 pd reset", {7'd0, sda_pd}, 8'h00);

    // R5 / R4: same register rewritten, bits [6:4] set
    dbuf[0] = 8'hA1; dbuf[1] = 8'hB2; dbuf[2] = 8'hC3;
    xfer(8'h80, 8'h72, 3, "R5 no-inc");

    // R6 / R7: burst from 8 through 10..15 wrapping to 0 and 1
    for (int k = 0; k < 10; k++) dbuf[k] = 8'(8'h10 + k);
    xfer(8'h80, 8'h88, 10, "R6 wrap");

    // R3: wrong address, no ack, no change
    dbuf[0] = 8'h55; dbuf[1] = 8'h66;
    xfer(8'h82, 8'h85, 2, "R3 mismatch");

    // R2: strap high selects 0x82
    strap = 1'b1;
    dbuf[0] = 8'h3C;
    xfer(8'h82, 8'h05, 1, "R2 alt addr");
    dbuf[0] = 8'h4D;
    xfer(8'h80, 8'h05, 1, "R2 base rejected");
    strap = 1'b0;

    // R7: direct write to index 12 ignored but acked
    dbuf[0] = 8'hEE;
    xfer(8'h80, 8'h0C, 1, "R7 hole");

    // R9: STOP mid-byte discards partial byte
    bus_start();
    send_byte(8'h80, ack);
    send_byte(8'h06, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    bus_stop();
    chk_regs("R9 partial");

    // R9: repeated START restarts address reception
    bus_start();
    send_byte(8'h80, ack);
    send_byte(8'h01, ack);
    send_byte(8'h9A, ack);
    exp_q[1] = 8'h9A;
    bus_start();
    send_byte(8'h80, ack);
    check(ack == 1'b1, "R9 restart ack", {7'd0, ack}, 8'h01);
    send_byte(8'h04, ack);
    send_byte(8'h2B, ack);
    exp_q[4] = 8'h2B;
    bus_stop();
    chk_regs("R9 restart");

    // R1: byte without START ignored
    scl_m = 1'b0; wt(4);
    send_byte(8'h80, ack);
    check(ack == 1'b0, "R1 no start ack", {7'd0, ack}, 8'h00);
    send_byte(8'h02, ack);
    send_byte(8'h77, ack);
    scl_m = 1'b1; wt(8);
    chk_regs("R1 no start");

    // random transfers
    for (int t = 0; t < 25; t++) begin
      logic [7:0] a;
      int n;
      strap = 1'($urandom);
      a = ($urandom % 5 == 0) ? 8'h84 : (strap ? 8'h82 : 8'h80);
      n = 1 + int'($urandom % 6);
      for (int k = 0; k < n; k++) dbuf[k] = 8'($urandom);
      xfer(a, 8'($urandom), n, "R6 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule